// File: doc/BRIEF.md
# Key-Committed Protected Reset Configuration Register

This peripheral guards reset-related settings so that one stray write cannot change them. Software first puts new values into a staging register, or into a separate flag-staging register. The staged values do nothing yet. They take effect only when software writes an unlock code to a key register at another address. Each of three codes moves its own group of staged bits into the active state. Every other code is discarded.

The key register cannot be read. A read of its address returns a status word that shows the active settings. Unlock codes are accepted only while the clock-gear select input is 2'b00. The active reset-disable setting survives a general reset and is cleared only by power-on reset. Committing the flag-clear bit does not store anything: it produces a single-cycle pulse. Both resets are synchronous and active high, and power-on reset takes priority over general reset.

Top module: `prot_cfg_top`

## Requirements
- R1: Writing to address 0 stores data bits 2:0 in the staging register: bit 0 is the disable value, bit 1 the area value and bit 2 the vector value. Writing to address 1 stores data bit 0 as the staged flag-clear value. Reads of either address return the stored bits, and all other bits read as 0.
- R2: Writing 8'hB2 to address 2 copies the staged disable bit into the active disable output on the next clock edge. Area and vector stay unchanged.
- R3: Writing 8'hD4 to address 2 copies the staged area and vector bits together into their active outputs on the next clock edge. Disable stays unchanged.
- R4: Writing 8'h71 to address 2 while the staged flag-clear bit is 1 raises the flag-clear output for exactly one cycle. No status bit keeps the result. With the staged bit at 0, no pulse is produced.
- R5: Writing any code other than 8'hB2, 8'hD4 or 8'h71 to address 2 leaves the active outputs, the status word and the flag-clear output unchanged.
- R6: Reading address 2 returns the status word, with bit 0 = active disable, bit 1 = active area, bit 2 = active vector, and bits 7:3 = 0. A read of address 3, or any cycle with the read strobe low, returns 0.
- R7: While the gear select is not 2'b00, a valid unlock code is ignored. The active outputs stay unchanged and no pulse is produced.
- R8: General reset clears both staging registers and the active area and vector bits, but keeps the active disable bit.
- R9: Power-on reset clears all staging and active state and the flag-clear output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| rst_i | input | 1 | General reset, synchronous, active high |
| gear_sel_i | input | 2 | Clock-gear select; unlock codes are accepted only at 2'b00 |
| addr_i | input | ADDR_W (2) | Register address |
| wdata_i | input | DATA_W (8) | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W (8) | Read data (combinational, 0 when rd_i is low) |
| rst_dis_o | output | 1 | Active external-reset disable |
| rst_area_o | output | 1 | Active reset-area select |
| rst_vec_o | output | 1 | Active reset-vector select |
| flag_clr_o | output | 1 | Single-cycle flag-clear pulse |

## Verification
The assertions check, on every cycle:
- that a rejected code, or a valid code under a non-zero gear select, leaves the active state untouched;
- that each commit copies the staged value one edge later;
- that general reset does not disturb the disable bit;
- that the status readback keeps its upper bits at 0;
- that every flag-clear pulse comes from an accepted 8'h71 write.

Only the bench's scenarios can show the longer sequences: that a commit actually moves the bits that were staged earlier, that a pulse lasts exactly one cycle and leaves no trace in the status word, and that the disable bit committed before a general reset is still reported afterwards while the other fields are cleared.

// File: rtl/prot_cfg_pkg.sv
package prot_cfg_pkg;

    localparam int KEY_W = 8;
    localparam int CTL_W = 3;

    localparam logic [KEY_W-1:0] KEY_DIS      = 8'hB2;
    localparam logic [KEY_W-1:0] KEY_AREA_VEC = 8'hD4;
    localparam logic [KEY_W-1:0] KEY_FLAG     = 8'h71;

    // bit 0 disable, bit 1 area, bit 2 vector
    typedef struct packed {
        logic vec;
        logic area;
        logic dis;
    } rst_ctl_t;

    typedef enum logic [1:0] {
        CMT_NONE,
        CMT_DIS,
        CMT_AREA_VEC,
        CMT_FLAG
    } commit_e;

    function automatic commit_e key_to_commit(input logic [KEY_W-1:0] code);
        commit_e c;
        case (code)
            KEY_DIS:      c = CMT_DIS;
            KEY_AREA_VEC: c = CMT_AREA_VEC;
            KEY_FLAG:     c = CMT_FLAG;
            default:      c = CMT_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/prot_cfg_stage.sv
module prot_cfg_stage
    import prot_cfg_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 por_i,
    input  logic                 rst_i,
    input  logic                 wr_cfg_i,
    input  logic                 wr_flag_i,
    input  logic [CTL_W-1:0]     cfg_data_i,
    input  logic                 flag_data_i,
    output rst_ctl_t             cfg_q_o,
    output logic                 flag_q_o
);

    always_ff @(posedge clk_i) begin
        if (por_i || rst_i) begin
            cfg_q_o  <= '0;
            flag_q_o <= 1'b0;
        end else begin
            if (wr_cfg_i)  cfg_q_o  <= rst_ctl_t'(cfg_data_i);
            if (wr_flag_i) flag_q_o <= flag_data_i;
        end
    end

    // R1
    stage_wr_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        wr_cfg_i |=> cfg_q_o == rst_ctl_t'($past(cfg_data_i)));

endmodule

// File: rtl/prot_cfg_keydec.sv
module prot_cfg_keydec
    import prot_cfg_pkg::*;
#(
    parameter int GEAR_W = 2
) (
    input  logic                 wr_key_i,
    input  logic [KEY_W-1:0]     code_i,
    input  logic [GEAR_W-1:0]    gear_i,
    output commit_e              cmt_o
);

    logic gear_ok;
    assign gear_ok = (gear_i == '0);

    always_comb begin
        cmt_o = CMT_NONE;
        if (wr_key_i && gear_ok) cmt_o = key_to_commit(code_i);
    end

endmodule

// File: rtl/prot_cfg_active.sv
module prot_cfg_active
    import prot_cfg_pkg::*;
(
    input  logic      clk_i,
    input  logic      por_i,
    input  logic      rst_i,
    input  commit_e   cmt_i,
    input  rst_ctl_t  cfg_i,
    input  logic      flag_i,
    output rst_ctl_t  act_o,
    output logic      clr_pulse_o
);

    // disable bit: power-on reset only
    always_ff @(posedge clk_i) begin
        if (por_i)                           act_o.dis <= 1'b0;
        else if (!rst_i && cmt_i == CMT_DIS) act_o.dis <= cfg_i.dis;
    end

    always_ff @(posedge clk_i) begin
        if (por_i || rst_i) begin
            act_o.area  <= 1'b0;
            act_o.vec   <= 1'b0;
            clr_pulse_o <= 1'b0;
        end else begin
            if (cmt_i == CMT_AREA_VEC) begin
                act_o.area <= cfg_i.area;
                act_o.vec  <= cfg_i.vec;
            end
            clr_pulse_o <= (cmt_i == CMT_FLAG) && flag_i;
        end
    end

    // R8
    dis_keep_chk: assert property (@(posedge clk_i) disable iff (por_i)
        rst_i |=> $stable(act_o.dis));

    // R9
    por_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        por_i |=> (act_o == '0) && !clr_pulse_o);

    // R3
    area_vec_pair_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (cmt_i == CMT_AREA_VEC) |=> (act_o.area == $past(cfg_i.area)) &&
                                   (act_o.vec == $past(cfg_i.vec)) &&
                                   $stable(act_o.dis));

    // R2
    dis_commit_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (cmt_i == CMT_DIS) |=> (act_o.dis == $past(cfg_i.dis)) &&
                              $stable(act_o.area) && $stable(act_o.vec));

endmodule

// File: rtl/prot_cfg_top.sv
module prot_cfg_top
    import prot_cfg_pkg::*;
#(
    parameter int                ADDR_W    = 2,
    parameter int                DATA_W    = 8,
    parameter int                GEAR_W    = 2,
    parameter logic [ADDR_W-1:0] ADDR_CFG  = 2'd0,
    parameter logic [ADDR_W-1:0] ADDR_FLAG = 2'd1,
    parameter logic [ADDR_W-1:0] ADDR_KEY  = 2'd2
) (
    input  logic              clk_i,
    input  logic              por_i,
    input  logic              rst_i,
    input  logic [GEAR_W-1:0] gear_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rst_dis_o,
    output logic              rst_area_o,
    output logic              rst_vec_o,
    output logic              flag_clr_o
);

    localparam int PAD_W = DATA_W - CTL_W;

    logic     wr_cfg, wr_flag, wr_key;
    rst_ctl_t cfg_q, act_q;
    logic     flag_q;
    commit_e  cmt;

    assign wr_cfg  = wr_i && (addr_i == ADDR_CFG);
    assign wr_flag = wr_i && (addr_i == ADDR_FLAG);
    assign wr_key  = wr_i && (addr_i == ADDR_KEY);

    prot_cfg_stage u_stage (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .rst_i       (rst_i),
        .wr_cfg_i    (wr_cfg),
        .wr_flag_i   (wr_flag),
        .cfg_data_i  (wdata_i[CTL_W-1:0]),
        .flag_data_i (wdata_i[0]),
        .cfg_q_o     (cfg_q),
        .flag_q_o    (flag_q)
    );

    prot_cfg_keydec #(.GEAR_W(GEAR_W)) u_keydec (
        .wr_key_i (wr_key),
        .code_i   (wdata_i[KEY_W-1:0]),
        .gear_i   (gear_sel_i),
        .cmt_o    (cmt)
    );

    prot_cfg_active u_active (
        .clk_i       (clk_i),
        .por_i       (por_i),
        .rst_i       (rst_i),
        .cmt_i       (cmt),
        .cfg_i       (cfg_q),
        .flag_i      (flag_q),
        .act_o       (act_q),
        .clr_pulse_o (flag_clr_o)
    );

    assign rst_dis_o  = act_q.dis;
    assign rst_area_o = act_q.area;
    assign rst_vec_o  = act_q.vec;

    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            case (addr_i)
                ADDR_CFG:  rdata_o = {{PAD_W{1'b0}}, cfg_q};
                ADDR_FLAG: rdata_o = {{(DATA_W-1){1'b0}}, flag_q};
                ADDR_KEY:  rdata_o = {{PAD_W{1'b0}}, act_q};
                default:   rdata_o = '0;
            endcase
        end
    end

    // R6
    status_pad_chk: assert property (@(posedge clk_i) disable iff (por_i)
        (rd_i && addr_i == ADDR_KEY) |-> (rdata_o[DATA_W-1:CTL_W] == '0));

    // R7
    gear_block_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (wr_i && addr_i == ADDR_KEY && gear_sel_i != '0) |=>
            $stable({rst_dis_o, rst_area_o, rst_vec_o}) && !flag_clr_o);

    // R5
    bad_key_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        (wr_i && addr_i == ADDR_KEY && wdata_i[KEY_W-1:0] != KEY_DIS &&
         wdata_i[KEY_W-1:0] != KEY_AREA_VEC && wdata_i[KEY_W-1:0] != KEY_FLAG) |=>
            $stable({rst_dis_o, rst_area_o, rst_vec_o}) && !flag_clr_o);

    // R4
    pulse_src_chk: assert property (@(posedge clk_i) disable iff (por_i || rst_i)
        $rose(flag_clr_o) |-> $past(wr_i && addr_i == ADDR_KEY &&
                                    wdata_i[KEY_W-1:0] == KEY_FLAG && gear_sel_i == '0));

endmodule

// File: tb/prot_cfg_top_tb_top.sv
module prot_cfg_top_tb_top;

    logic       clk = 1'b0;
    logic       por_i = 1'b1, rst_i = 1'b0;
    logic [1:0] gear_sel_i = 2'b00;
    logic [1:0] addr_i = '0;
    logic [7:0] wdata_i = '0;
    logic       wr_i = 1'b0, rd_i = 1'b0;
    logic [7:0] rdata_o;
    logic       rst_dis_o, rst_area_o, rst_vec_o, flag_clr_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    prot_cfg_top dut_i (
        .clk_i(clk), .por_i(por_i), .rst_i(rst_i), .gear_sel_i(gear_sel_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i),
        .rdata_o(rdata_o), .rst_dis_o(rst_dis_o), .rst_area_o(rst_area_o),
        .rst_vec_o(rst_vec_o), .flag_clr_o(flag_clr_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares read data against queued expectations
    always @(negedge clk) begin
        if (rd_i && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rdata_o, e);
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(posedge clk); #1;
        wr_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        addr_i = a; rd_i = 1'b1;
        @(posedge clk); #1;
        rd_i = 1'b0;
    endtask

    task automatic pins(input logic [3:0] e, input string tag);
        chk(tag, {4'h0, flag_clr_o, rst_vec_o, rst_area_o, rst_dis_o}, {4'h0, e});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(posedge clk); @(posedge clk); #1;
        por_i = 1'b0;
        pins(4'b0000, "R9 outputs after power-on");
        bus_rd(2'd2, 8'h00, "R9 status after power-on");
        bus_rd(2'd0, 8'h00, "R9 staging after power-on");
        bus_rd(2'd1, 8'h00, "R9 flag staging after power-on");

        bus_wr(2'd0, 8'hFF);
        bus_rd(2'd0, 8'h07, "R1 staging readback pads 7:3");
        bus_rd(2'd2, 8'h00, "R2 staged values not active yet");
        rd_i = 1'b0; addr_i = 2'd0;
        #1 chk("R6 no read strobe returns 0", rdata_o, 8'h00);

        bus_wr(2'd2, 8'hB2);
        pins(4'b0001, "R2 disable commit only");
        bus_rd(2'd2, 8'h01, "R2 status after B2");

        bus_wr(2'd0, 8'h06);
        bus_wr(2'd2, 8'hD4);
        pins(4'b0111, "R3 area and vector commit");
        bus_rd(2'd2, 8'h07, "R3 status after D4");

        bus_wr(2'd0, 8'h00);
        bus_wr(2'd2, 8'h55);
        bus_wr(2'd2, 8'hB3);
        pins(4'b0111, "R5 invalid codes ignored");
        bus_rd(2'd2, 8'h07, "R5 status unchanged");

        gear_sel_i = 2'b01;
        bus_wr(2'd2, 8'hB2);
        bus_wr(2'd2, 8'hD4);
        pins(4'b0111, "R7 gear not 00 blocks commit");
        bus_rd(2'd2, 8'h07, "R7 status unchanged");
        gear_sel_i = 2'b00;

        bus_wr(2'd1, 8'hFF);
        bus_rd(2'd1, 8'h01, "R1 flag staging readback");
        bus_wr(2'd2, 8'h71);
        pins(4'b1111, "R4 clear pulse high");
        @(posedge clk); #1;
        pins(4'b0111, "R4 clear pulse one cycle");
        bus_rd(2'd2, 8'h07, "R4 no persistent status bit");
        bus_wr(2'd1, 8'h00);
        bus_wr(2'd2, 8'h71);
        pins(4'b0111, "R4 no pulse with staged 0");

        bus_wr(2'd1, 8'h01);
        gear_sel_i = 2'b10;
        bus_wr(2'd2, 8'h71);
        pins(4'b0111, "R7 no pulse under gear 10");
        gear_sel_i = 2'b00;

        bus_wr(2'd0, 8'h05);
        rst_i = 1'b1; @(posedge clk); #1; rst_i = 1'b0;
        pins(4'b0001, "R8 general reset keeps disable only");
        bus_rd(2'd2, 8'h01, "R8 status after general reset");
        bus_rd(2'd0, 8'h00, "R8 staging cleared");
        bus_rd(2'd1, 8'h00, "R8 flag staging cleared");
        bus_rd(2'd3, 8'h00, "R6 unmapped address reads 0");

        bus_wr(2'd2, 8'hB2);
        pins(4'b0000, "R2 commit of staged 0 clears disable");

        bus_wr(2'd0, 8'h07);
        bus_wr(2'd2, 8'hB2);
        pins(4'b0001, "R2 disable set again");
        por_i = 1'b1; @(posedge clk); #1; por_i = 1'b0;
        pins(4'b0000, "R9 power-on clears disable");
        bus_rd(2'd0, 8'h00, "R9 staging cleared by power-on");

        @(posedge clk); #1;
        finish_run();
    end

endmodule